// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller

This block holds the control state for one eight-pin general-purpose I/O port and turns it into the per-pin signals a pad cell needs. Software reaches the state through a single-cycle register bus with a 4-bit word address and 8-bit data. The pad side gets, for every pin, an output value, an output enable, pull-up and pull-down enables, an input-buffer enable and a slew select, plus one port-wide input-threshold select. The fabric side supplies an alternative output value and a dynamic output enable for every pin, and receives the conditioned digital input.

Each pin's drive mode is a 3-bit number built from the same bit of three port-wide mode registers. Per-pin bits choose the output source, hand the output enable to the fabric, block the digital input, add a two-flop input synchroniser and retime the output on the bus clock. An index register plus a window register give one access to a single pin's data, mode and slew bits, and a port-wide mask limits which pins' data bits the window may change. While reset is held, a static 2-bit input chooses a safe pad state; after reset every pin sits in analog high-impedance until software configures it.

Top module: `gpio_port_ctl`

## Requirements
- R1: Registers are read combinationally with no side effect at these word addresses: 0 output data, 1 pin state (read-only), 2/3/4 mode bit 0/1/2, 5 slew, 6 output-source select, 7 fabric output-enable select, 8 input block, 9 input sync, 10 output retime, 11 control (bit 0 threshold), 12 window data mask, 13 window pin index (bits 2:0), 14 pin window, 15 unused. All reset to zero; a write to 1 or 15 changes nothing and 15 reads zero.
- R2: Pin i's mode is m = 4*mode2[i] + 2*mode1[i] + mode0[i]; with output value v the pad controls are: m=0 all off including the input buffer; m=1 input only; m=2 pull-up enable = v, output enable = !v; m=3 pull-down enable = !v, output enable = v; m=4 output enable = !v; m=5 output enable = v; m=6 output enable = 1; m=7 pull-up = v, pull-down = !v, output enable = 0. The input buffer is on for m=1..7 and the pad output value is always v.
- R3: The pin-state bit of any pin in mode 0 reads 0, whatever the pad level.
- R4: While reset is low every output enable is 0 and the reset mode input sets the pad: 00 analog off, 01 pull-up, 10 pull-down, 11 input only (input buffer on for 01, 10, 11). After release all pins are in mode 0.
- R5: With the source-select bit at 1 the pin's output value is the fabric value; at 0 it is the output data bit.
- R6: With the fabric output-enable select bit at 1 the pin's output enable equals the fabric enable, whatever the mode.
- R7: With the input-block bit at 1 the pin's fabric input and pin-state bit read 0.
- R8: With the input-sync bit at 1 the pad level (gated by the input buffer) reaches the fabric input after two clock edges; at 0 it passes with no delay.
- R9: With the retime bit at 1 the pad output value is the selected source value captured at the previous clock edge.
- R10: The window (address 14) reads {0,0, pin state, slew, mode2, mode1, mode0, data} of the indexed pin; a write always updates that pin's mode and slew bits (4:1) and updates its data bit (bit 0) only when the pin's mask bit is 1.
- R11: Each slew bit drives the pin's slew output and control bit 0 drives the threshold output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_mode | input | 2 | Pad state applied while reset is held |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |
| pad_ien | output | 8 | Input-buffer enables |
| pad_slew | output | 8 | Slew selects |
| pad_thresh | output | 1 | Input threshold select |
| fab_out | input | 8 | Fabric output values |
| fab_oe | input | 8 | Fabric output enables |
| fab_in | output | 8 | Conditioned digital input to fabric |

## Verification
The properties assume the bus presents one address and at most one write per cycle, and that the window index register is written before the window is used; the bench drives every bus and pad input half a cycle away from the clock edge, so each write is a single clean strobe. The retime and synchroniser properties rely on reset covering at least one edge before any sampled history counts, which the bench guarantees by holding reset for several cycles at start and again mid-run. Random stimulus keeps to legal 4-bit addresses and arbitrary data, so masked and unmasked window writes and mode changes mix freely.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PST    = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_MODE0  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_MODE1  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MODE2  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_SLEW   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_SRCSEL = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_FOESEL = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_INBLK  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_INSYNC = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_RETIME = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_INDEX  = 4'd13;
  localparam logic [ADDR_W-1:0] ADR_WINDOW = 4'd14;

  // window field positions
  localparam int WIN_DATA  = 0;
  localparam int WIN_M0    = 1;
  localparam int WIN_M1    = 2;
  localparam int WIN_M2    = 3;
  localparam int WIN_SLEW  = 4;
  localparam int WIN_STATE = 5;

  typedef enum logic [2:0] {
    DM_ANALOG   = 3'd0,
    DM_INPUT    = 3'd1,
    DM_PULLUP   = 3'd2,
    DM_PULLDN   = 3'd3,
    DM_SINK     = 3'd4,
    DM_SOURCE   = 3'd5,
    DM_STRONG   = 3'd6,
    DM_PULLBOTH = 3'd7
  } drive_mode_e;

  typedef enum logic [1:0] {
    RM_ANALOG = 2'd0,
    RM_PULLUP = 2'd1,
    RM_PULLDN = 2'd2,
    RM_INPUT  = 2'd3
  } reset_mode_e;

  typedef struct packed {
    logic oe;
    logic pu;
    logic pd;
    logic ien;
  } pad_ctl_t;

  function automatic pad_ctl_t decode_mode(drive_mode_e m, logic v);
    pad_ctl_t c;
    c = '0;
    c.ien = (m != DM_ANALOG);
    unique case (m)
      DM_ANALOG:   ;
      DM_INPUT:    ;
      DM_PULLUP:   begin c.pu = v;  c.oe = ~v; end
      DM_PULLDN:   begin c.pd = ~v; c.oe = v;  end
      DM_SINK:     c.oe = ~v;
      DM_SOURCE:   c.oe = v;
      DM_STRONG:   c.oe = 1'b1;
      DM_PULLBOTH: begin c.pu = v;  c.pd = ~v; end
      default:     c = '0;
    endcase
    return c;
  endfunction

  function automatic pad_ctl_t reset_ctl(reset_mode_e r);
    pad_ctl_t c;
    c     = '0;
    c.pu  = (r == RM_PULLUP);
    c.pd  = (r == RM_PULLDN);
    c.ien = (r != RM_ANALOG);
    return c;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic en,
  output logic q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic prev;
    logic q_st;
    if (g == 0) begin : g_first
      assign prev = d;
    end else begin : g_next
      assign prev = g_st[g-1].q_st;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_st <= 1'b0;
      else        q_st <= prev;
    end
  end

  assign q = en ? g_st[STAGES-1].q_st : d;

endmodule

// File: rtl/gpio_pin_slice.sv
`timescale 1ns/1ps
module gpio_pin_slice
  import gpio_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rst_mode,
  input  logic [2:0] mode,
  input  logic       data,
  input  logic       src_sel,
  input  logic       foe_sel,
  input  logic       in_blk,
  input  logic       in_sync,
  input  logic       retime,
  input  logic       fab_out,
  input  logic       fab_oe,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_pu,
  output logic       pad_pd,
  output logic       pad_ien,
  output logic       fab_in,
  output logic       pin_state,
  output logic       out_src,
  output logic       analog
);

  pad_ctl_t op_ctl;
  pad_ctl_t rs_ctl;
  pad_ctl_t ctl;
  logic     out_q;
  logic     val;
  logic     raw;
  logic     synced;

  assign out_src = src_sel ? fab_out : data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_src;
  end

  assign val = retime ? out_q : out_src;

  always_comb begin
    op_ctl = decode_mode(drive_mode_e'(mode), val);
    if (foe_sel) op_ctl.oe = fab_oe;
    rs_ctl = reset_ctl(reset_mode_e'(rst_mode));
    ctl    = rst_n ? op_ctl : rs_ctl;
  end

  assign analog  = rst_n ? (mode == DM_ANALOG) : (rst_mode == RM_ANALOG);
  assign pad_out = val;
  assign pad_oe  = ctl.oe;
  assign pad_pu  = ctl.pu;
  assign pad_pd  = ctl.pd;
  assign pad_ien = ctl.ien;

  assign raw = pad_in & ctl.ien;

  gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .en    (in_sync),
    .q     (synced)
  );

  assign fab_in    = synced & ~in_blk;
  assign pin_state = fab_in & ~analog;

endmodule

// File: rtl/gpio_bus_regs.sv
`timescale 1ns/1ps
module gpio_bus_regs
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int SEL_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  input  logic [N_PINS-1:0] pin_state,
  output logic [N_PINS-1:0] rdata,
  output logic [N_PINS-1:0] data_q,
  output logic [N_PINS-1:0] m0_q,
  output logic [N_PINS-1:0] m1_q,
  output logic [N_PINS-1:0] m2_q,
  output logic [N_PINS-1:0] slew_q,
  output logic [N_PINS-1:0] src_q,
  output logic [N_PINS-1:0] foe_q,
  output logic [N_PINS-1:0] blk_q,
  output logic [N_PINS-1:0] isync_q,
  output logic [N_PINS-1:0] retime_q,
  output logic [N_PINS-1:0] mask_q,
  output logic              thresh_q,
  output logic [SEL_W-1:0]  sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      m0_q     <= '0;
      m1_q     <= '0;
      m2_q     <= '0;
      slew_q   <= '0;
      src_q    <= '0;
      foe_q    <= '0;
      blk_q    <= '0;
      isync_q  <= '0;
      retime_q <= '0;
      mask_q   <= '0;
      thresh_q <= 1'b0;
      sel_q    <= '0;
    end else if (we) begin
      unique case (addr)
        ADR_DATA:   data_q   <= wdata;
        ADR_MODE0:  m0_q     <= wdata;
        ADR_MODE1:  m1_q     <= wdata;
        ADR_MODE2:  m2_q     <= wdata;
        ADR_SLEW:   slew_q   <= wdata;
        ADR_SRCSEL: src_q    <= wdata;
        ADR_FOESEL: foe_q    <= wdata;
        ADR_INBLK:  blk_q    <= wdata;
        ADR_INSYNC: isync_q  <= wdata;
        ADR_RETIME: retime_q <= wdata;
        ADR_CTRL:   thresh_q <= wdata[0];
        ADR_MASK:   mask_q   <= wdata;
        ADR_INDEX:  sel_q    <= wdata[SEL_W-1:0];
        ADR_WINDOW: begin
          if (mask_q[sel_q]) data_q[sel_q] <= wdata[WIN_DATA];
          m0_q[sel_q]   <= wdata[WIN_M0];
          m1_q[sel_q]   <= wdata[WIN_M1];
          m2_q[sel_q]   <= wdata[WIN_M2];
          slew_q[sel_q] <= wdata[WIN_SLEW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_DATA:   rdata = data_q;
      ADR_PST:    rdata = pin_state;
      ADR_MODE0:  rdata = m0_q;
      ADR_MODE1:  rdata = m1_q;
      ADR_MODE2:  rdata = m2_q;
      ADR_SLEW:   rdata = slew_q;
      ADR_SRCSEL: rdata = src_q;
      ADR_FOESEL: rdata = foe_q;
      ADR_INBLK:  rdata = blk_q;
      ADR_INSYNC: rdata = isync_q;
      ADR_RETIME: rdata = retime_q;
      ADR_CTRL:   rdata[0] = thresh_q;
      ADR_MASK:   rdata = mask_q;
      ADR_INDEX:  rdata[SEL_W-1:0] = sel_q;
      ADR_WINDOW: begin
        rdata[WIN_DATA]  = data_q[sel_q];
        rdata[WIN_M0]    = m0_q[sel_q];
        rdata[WIN_M1]    = m1_q[sel_q];
        rdata[WIN_M2]    = m2_q[sel_q];
        rdata[WIN_SLEW]  = slew_q[sel_q];
        rdata[WIN_STATE] = pin_state[sel_q];
      end
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_ctl.sv
`timescale 1ns/1ps
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rst_mode,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_pu,
  output logic [N_PINS-1:0] pad_pd,
  output logic [N_PINS-1:0] pad_ien,
  output logic [N_PINS-1:0] pad_slew,
  output logic              pad_thresh,
  input  logic [N_PINS-1:0] fab_out,
  input  logic [N_PINS-1:0] fab_oe,
  output logic [N_PINS-1:0] fab_in
);

  localparam int SEL_W = $clog2(N_PINS);

  logic [N_PINS-1:0] data_q, m0_q, m1_q, m2_q, slew_q;
  logic [N_PINS-1:0] src_q, foe_q, blk_q, isync_q, retime_q, mask_q;
  logic              thresh_q;
  logic [SEL_W-1:0]  sel_q;
  logic [N_PINS-1:0] pin_state;
  logic [N_PINS-1:0] out_src;
  logic [N_PINS-1:0] analog_mask;

  gpio_bus_regs #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .pin_state (pin_state),
    .rdata     (bus_rdata),
    .data_q    (data_q),
    .m0_q      (m0_q),
    .m1_q      (m1_q),
    .m2_q      (m2_q),
    .slew_q    (slew_q),
    .src_q     (src_q),
    .foe_q     (foe_q),
    .blk_q     (blk_q),
    .isync_q   (isync_q),
    .retime_q  (retime_q),
    .mask_q    (mask_q),
    .thresh_q  (thresh_q),
    .sel_q     (sel_q)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_mode  (rst_mode),
      .mode      ({m2_q[i], m1_q[i], m0_q[i]}),
      .data      (data_q[i]),
      .src_sel   (src_q[i]),
      .foe_sel   (foe_q[i]),
      .in_blk    (blk_q[i]),
      .in_sync   (isync_q[i]),
      .retime    (retime_q[i]),
      .fab_out   (fab_out[i]),
      .fab_oe    (fab_oe[i]),
      .pad_in    (pad_in[i]),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .pad_pu    (pad_pu[i]),
      .pad_pd    (pad_pd[i]),
      .pad_ien   (pad_ien[i]),
      .fab_in    (fab_in[i]),
      .pin_state (pin_state[i]),
      .out_src   (out_src[i]),
      .analog    (analog_mask[i])
    );
  end

  assign pad_slew   = slew_q;
  assign pad_thresh = thresh_q;

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int SEL_W  = $clog2(N_PINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] bus_rdata,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_oe,
  input logic              pad_thresh,
  input logic [N_PINS-1:0] fab_oe,
  input logic [N_PINS-1:0] fab_in,
  input logic [N_PINS-1:0] data_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [N_PINS-1:0] foe_q,
  input logic [N_PINS-1:0] blk_q,
  input logic [N_PINS-1:0] retime_q,
  input logic [N_PINS-1:0] out_src,
  input logic [N_PINS-1:0] analog_mask
);

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_DATA) |=> (data_q == $past(bus_wdata))) else $error("data write"); // R1

  AST_ANALOG_STATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_PST) |-> ((bus_rdata & analog_mask) == '0)) else $error("analog state"); // R3

  AST_FABRIC_OE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((pad_oe ^ fab_oe) & foe_q) == '0)) else $error("fabric oe"); // R6

  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((fab_in & blk_q) == '0)) else $error("input block"); // R7

  AST_RETIME_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pad_out ^ $past(out_src)) & retime_q & $past(retime_q)) == '0)) else $error("retime"); // R9

  AST_MASKED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_WINDOW && !mask_q[sel_q]) |=> (data_q == $past(data_q))) else $error("masked window"); // R10

  AST_THRESH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADR_CTRL) |=> (pad_thresh == $past(bus_wdata[0]))) else $error("threshold"); // R11

endmodule

bind gpio_port_ctl gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_thresh  (pad_thresh),
  .fab_oe      (fab_oe),
  .fab_in      (fab_in),
  .data_q      (data_q),
  .mask_q      (mask_q),
  .sel_q       (sel_q),
  .foe_q       (foe_q),
  .blk_q       (blk_q),
  .retime_q    (retime_q),
  .out_src     (out_src),
  .analog_mask (analog_mask)
);

// File: tb/tb_gpio_port_ctl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rst_mode = 2'd1;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu, pad_pd, pad_ien, pad_slew, fab_in;
  logic       pad_thresh;
  logic [7:0] fab_out = 8'h00;
  logic [7:0] fab_oe = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_port_ctl dut (
    .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_ien(pad_ien), .pad_slew(pad_slew), .pad_thresh(pad_thresh),
    .fab_out(fab_out), .fab_oe(fab_oe), .fab_in(fab_in)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_reg [0:15];   // indexed by address; 1 and 15 unused
  logic [2:0] m_sel;
  logic [7:0] m_s1, m_s2, m_oq;

  function automatic int mode_of(int i);
    return int'(m_reg[4][i]) * 4 + int'(m_reg[3][i]) * 2 + int'(m_reg[2][i]);
  endfunction

  function automatic bit ien_of(int i);
    if (!rst_n) return rst_mode != 2'd0;
    return mode_of(i) != 0;
  endfunction

  function automatic logic [7:0] src_vec();
    return (m_reg[6] & fab_out) | (~m_reg[6] & m_reg[0]);
  endfunction

  function automatic logic [7:0] raw_vec();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = pad_in[i] & ien_of(i);
    return r;
  endfunction

  function automatic logic [7:0] fin_vec();
    return ((m_reg[9] & m_s2) | (~m_reg[9] & raw_vec())) & ~m_reg[8];
  endfunction

  function automatic logic [7:0] pst_vec();
    logic [7:0] f, p;
    f = fin_vec();
    for (int i = 0; i < 8; i++) begin
      if (!rst_n) p[i] = (rst_mode == 2'd0) ? 1'b0 : f[i];
      else        p[i] = (mode_of(i) == 0) ? 1'b0 : f[i];
    end
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) m_reg[a] = 8'h00;
      m_sel = 3'd0; m_s1 = 8'h00; m_s2 = 8'h00; m_oq = 8'h00;
    end else begin
      logic [7:0] r, s;
      r = raw_vec();
      s = src_vec();
      m_s2 = m_s1; m_s1 = r; m_oq = s;
      if (bus_we) begin
        if (bus_addr == 4'd13) m_sel = bus_wdata[2:0];
        else if (bus_addr == 4'd14) begin
          if (m_reg[12][m_sel]) m_reg[0][m_sel] = bus_wdata[0];
          m_reg[2][m_sel] = bus_wdata[1];
          m_reg[3][m_sel] = bus_wdata[2];
          m_reg[4][m_sel] = bus_wdata[3];
          m_reg[5][m_sel] = bus_wdata[4];
        end else if (bus_addr == 4'd11) m_reg[11] = {7'd0, bus_wdata[0]};
        else if (bus_addr != 4'd1 && bus_addr != 4'd15) m_reg[bus_addr] = bus_wdata;
      end
    end
  end

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 3 ns after the falling edge
  always begin
    logic [7:0] v, e_oe, e_pu, e_pd, e_ien, e_rd, pst;
    @(negedge clk);
    #3;
    v = (m_reg[10] & m_oq) | (~m_reg[10] & src_vec());
    for (int i = 0; i < 8; i++) begin
      bit oe, pu, pd;
      oe = 0; pu = 0; pd = 0;
      if (!rst_n) begin
        pu = (rst_mode == 2'd1);
        pd = (rst_mode == 2'd2);
      end else begin
        case (mode_of(i))
          2: begin pu = v[i];  oe = !v[i]; end
          3: begin pd = !v[i]; oe = v[i];  end
          4: oe = !v[i];
          5: oe = v[i];
          6: oe = 1;
          7: begin pu = v[i]; pd = !v[i]; end
          default: ;
        endcase
        if (m_reg[7][i]) oe = fab_oe[i];
      end
      e_oe[i] = oe; e_pu[i] = pu; e_pd[i] = pd; e_ien[i] = ien_of(i);
    end
    pst = pst_vec();
    case (bus_addr)
      4'd1:  e_rd = pst;
      4'd13: e_rd = {5'd0, m_sel};
      4'd14: e_rd = {2'b00, pst[m_sel], m_reg[5][m_sel], m_reg[4][m_sel],
                     m_reg[3][m_sel], m_reg[2][m_sel], m_reg[0][m_sel]};
      4'd15: e_rd = 8'h00;
      default: e_rd = m_reg[bus_addr];
    endcase
    check("R5 R9", "pad_out", pad_out, v);
    check("R2 R4 R6", "pad_oe", pad_oe, e_oe);
    check("R2 R4", "pad_pu", pad_pu, e_pu);
    check("R2 R4", "pad_pd", pad_pd, e_pd);
    check("R2 R4", "pad_ien", pad_ien, e_ien);
    check("R7 R8", "fab_in", fab_in, fin_vec());
    check("R1 R3 R10", "bus_rdata", bus_rdata, e_rd);
    check("R11", "slew/thresh", {pad_slew[6:0], pad_thresh}, {m_reg[5][6:0], m_reg[11][0]});
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R4: reset pad states for each reset-mode code
    pad_in = 8'hA5;
    idle(3); rst_mode = 2'd2;
    idle(2); rst_mode = 2'd3;
    idle(2); rst_mode = 2'd0;
    idle(2); rst_n = 1'b1;
    // R1: reset values of every register
    for (int a = 0; a < 16; a++) rd(a[3:0]);
    // R2: pins 0..7 get modes 0..7
    wr(4'd2, 8'hAA); wr(4'd3, 8'hCC); wr(4'd4, 8'hF0);
    foreach (pad_in[k]) ;
    for (int d = 0; d < 4; d++) begin
      wr(4'd0, (d == 0) ? 8'h00 : (d == 1) ? 8'hFF : (d == 2) ? 8'h5A : 8'hA5);
      pad_in = 8'hFF; rd(4'd1);  // R3 pin 0 is analog
      pad_in = 8'h3C; idle(2);
    end
    // R5: output source select
    wr(4'd6, 8'h0F);
    for (int k = 0; k < 4; k++) begin fab_out = 8'h11 << k; idle(1); end
    // R6: fabric output enable
    wr(4'd7, 8'h33);
    for (int k = 0; k < 4; k++) begin fab_oe = ~fab_oe ^ 8'h0F; idle(1); end
    // R7: input block
    pad_in = 8'hFF; wr(4'd8, 8'h81); rd(4'd1); idle(2); wr(4'd8, 8'h00);
    // R8: two-stage synchroniser
    wr(4'd9, 8'hFF);
    for (int k = 0; k < 6; k++) begin pad_in = ~pad_in; idle(1); end
    wr(4'd9, 8'h0F);
    for (int k = 0; k < 4; k++) begin pad_in = pad_in ^ 8'h99; idle(1); end
    // R9: output retime
    wr(4'd10, 8'hF0);
    wr(4'd0, 8'h3C); idle(1); wr(4'd0, 8'hC3); fab_out = 8'hFF; idle(2);
    // R11
    wr(4'd11, 8'h01); wr(4'd5, 8'h3C);
    // R10: window with mask
    wr(4'd12, 8'h55);
    wr(4'd13, 8'h02); wr(4'd14, 8'h1F); rd(4'd14); rd(4'd0);
    wr(4'd13, 8'h03); wr(4'd14, 8'h1F); rd(4'd14); rd(4'd0);
    wr(4'd14, 8'h00); rd(4'd14); rd(4'd2);
    // R1: reserved and read-only addresses ignore writes
    wr(4'd15, 8'hFF); rd(4'd15); wr(4'd1, 8'hFF); rd(4'd1);
    // R4 again mid-run
    @(negedge clk); rst_mode = 2'd3; rst_n = 1'b0; idle(3);
    rst_n = 1'b1; for (int a = 0; a < 16; a++) rd(a[3:0]);
    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      pad_in    = 8'($urandom);
      fab_out   = 8'($urandom);
      fab_oe    = 8'($urandom);
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = 4'($urandom);
      bus_wdata = 8'($urandom);
    end
    @(negedge clk); bus_we = 1'b0;
    idle(3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule